// File: doc/BRIEF.md
# Priority Transmit Queue

This block holds a small set of outgoing CAN frame buffers and decides which one goes out next. A writer checks the status outputs for a free slot (the put index) and for a full queue, fills the slot with two header words and a payload, and then raises that slot's bit on the add-request input. From then on the slot is pending. Among all pending slots, the block offers the frame with the numerically lowest 29-bit identifier to a serial transmit engine. Because CAN arbitration also favours low identifiers, this order avoids priority inversion.

The engine accepts the offered frame with a take pulse. It later reports one outcome: success, lost arbitration, or an error. On success the slot is freed and its per-slot transmitted flag is set. On a failure the slot either stays pending and competes again, or, when single-shot operation is selected, it is freed without the flag. An optional pause withholds the next offer for a fixed number of clock cycles after every successful frame.

Top module: `prio_txq`

## Requirements
- R1: After reset no slot is pending. The put index is 0, queue-full is low, all transmitted flags are 0 and no frame is offered.
- R2: The put index equals the lowest-numbered slot that is not pending. Queue-full is high exactly when every slot is pending, and the put index then reads 0.
- R3: A 1 in bit n of `add_req` makes slot n pending from the next cycle and clears its transmitted flag. For a slot that is already pending, the request has no effect.
- R4: Whenever a frame is offered, `eng_buf` names the pending slot whose identifier (header word 0, bits 28:0) is lowest. On equal identifiers, the lowest slot number wins.
- R5: A take pulse while `eng_valid` is high puts the offered slot in flight, and no offer is made while a slot is in flight. A completion with result 0 (success) frees that slot and sets its bit in `tx_sent`.
- R6: With `cfg_single_shot` low, result 1 (arbitration lost), result 2 (error) or result 3 (also error) leaves the slot pending, and the slot takes part in the next selection.
- R7: With `cfg_single_shot` high, a completion with result 1, 2 or 3 frees the slot and leaves its `tx_sent` bit at 0.
- R8: With `cfg_pause_en` high, a successful completion keeps `eng_valid` low for exactly PAUSE_CYC cycles after the completion edge.
- R9: The writer addresses words with `wr_word`: 0 is header word 0 (identifier in bits 28:0, remote bit 29, extended bit 30, error-state bit 31), 1 is header word 1, and 2 and up are payload words. The engine sees header word 0, header word 1 and the payload words exactly as written, with payload word k at bits 32k+31:32k. A write to a pending slot is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_single_shot | input | 1 | Free the slot after a failed attempt instead of retrying it |
| cfg_pause_en | input | 1 | Insert PAUSE_CYC idle cycles after each successful frame |
| wr_en | input | 1 | Write strobe for slot storage |
| wr_buf | input | IDX_W | Slot being written |
| wr_word | input | WSEL_W | Word select: 0 = header 0, 1 = header 1, 2 and up = payload |
| wr_data | input | 32 | Write data |
| add_req | input | NBUF | Per-slot request to mark the slot pending |
| put_idx | output | IDX_W | Lowest free slot |
| queue_full | output | 1 | All slots are pending |
| tx_sent | output | NBUF | Per-slot flag: the last frame in this slot was sent successfully |
| eng_valid | output | 1 | A frame is offered to the engine |
| eng_buf | output | IDX_W | Slot of the offered frame |
| eng_hdr0 | output | 32 | Header word 0 of the offered frame |
| eng_hdr1 | output | 32 | Header word 1 of the offered frame |
| eng_payload | output | PAY_WORDS*32 | Payload of the offered frame |
| eng_take | input | 1 | Engine accepts the offered frame |
| eng_done | input | 1 | Engine reports the end of the in-flight attempt |
| eng_res | input | 2 | Attempt result: 0 success, 1 arbitration lost, 2 or 3 error |

## Verification
Directed sequences load two slots with the same identifier and a third slot with a lower one. This separates the identifier order from the slot-number tie rule. The same sequences also try to overwrite a slot while it waits, and drive one lost arbitration followed by a success with the pause enabled. A long seeded random run then uses identifiers from a narrow range, so ties are frequent, and mixes writes, add requests (including requests for slots that are already pending) and all four result codes. Both the single-shot setting and the pause setting are switched on and off across phases of that run. Every cycle compares the put index, queue-full, the transmitted flags, the offer and its words against a bench model. A wrong free-slot choice, a wrong tie rule, a lost retry, a stale flag or a miscounted pause each show up as a different port mismatch.

// File: rtl/txq_pkg.sv
// Package: shared constants and the attempt-result encoding of the transmit queue.
package txq_pkg;
    localparam int ID_W   = 29;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        RES_OK   = 2'd0,
        RES_ARB  = 2'd1,
        RES_ERR  = 2'd2,
        RES_ERR3 = 2'd3
    } txq_res_e;
endpackage

// File: rtl/txq_store.sv
// Module: txq_store
// Holds both header words and the payload of every slot, and drives the
// words of one selected slot toward the engine.
// Assumes: the pending vector comes from the controller. Writes to a
// pending slot are dropped, so the offered frame stays stable.
module txq_store #(
    parameter int NBUF      = 3,
    parameter int PAY_WORDS = 2,
    localparam int IDX_W    = $clog2(NBUF),
    localparam int WSEL_W   = $clog2(PAY_WORDS + 2)
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [IDX_W-1:0]                       wr_buf,
    input  logic [WSEL_W-1:0]                      wr_word,
    input  logic [txq_pkg::WORD_W-1:0]             wr_data,
    input  logic [NBUF-1:0]                        pend,
    input  logic [IDX_W-1:0]                       rd_buf,
    output logic [NBUF-1:0][txq_pkg::ID_W-1:0]     keys,
    output logic [txq_pkg::WORD_W-1:0]             rd_hdr0,
    output logic [txq_pkg::WORD_W-1:0]             rd_hdr1,
    output logic [PAY_WORDS*txq_pkg::WORD_W-1:0]   rd_pay
);
    import txq_pkg::*;

    logic [WORD_W-1:0]           hdr0_q [NBUF];
    logic [WORD_W-1:0]           hdr1_q [NBUF];
    logic [PAY_WORDS*WORD_W-1:0] pay_q  [NBUF];

    for (genvar gi = 0; gi < NBUF; gi++) begin : g_slot
        logic slot_we;
        assign slot_we = wr_en && (wr_buf == IDX_W'(gi)) && !pend[gi];

        // Header word registers of one slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hdr0_q[gi] <= '0;
                hdr1_q[gi] <= '0;
            end else if (slot_we) begin
                if (wr_word == WSEL_W'(0)) hdr0_q[gi] <= wr_data;
                if (wr_word == WSEL_W'(1)) hdr1_q[gi] <= wr_data;
            end
        end

        for (genvar gk = 0; gk < PAY_WORDS; gk++) begin : g_word
            // One payload word register of one slot.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pay_q[gi][gk*WORD_W +: WORD_W] <= '0;
                end else if (slot_we && wr_word == WSEL_W'(gk + 2)) begin
                    pay_q[gi][gk*WORD_W +: WORD_W] <= wr_data;
                end
            end
        end

        assign keys[gi] = hdr0_q[gi][ID_W-1:0];
    end

    // Read multiplexer for the selected slot.
    always_comb begin
        rd_hdr0 = '0;
        rd_hdr1 = '0;
        rd_pay  = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (rd_buf == IDX_W'(i)) begin
                rd_hdr0 = hdr0_q[i];
                rd_hdr1 = hdr1_q[i];
                rd_pay  = pay_q[i];
            end
        end
    end
endmodule

// File: rtl/txq_pick.sv
// Module: txq_pick
// Finds the requesting slot with the smallest key. On equal keys the
// lower slot number wins.
// Assumes: keys are stable while they are compared (purely combinational).
module txq_pick #(
    parameter int NBUF   = 3,
    parameter int KEY_W  = 29,
    localparam int IDX_W = $clog2(NBUF)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NBUF-1:0]             req,
    input  logic [NBUF-1:0][KEY_W-1:0]  keys,
    output logic                        any,
    output logic [IDX_W-1:0]            idx
);
    logic [KEY_W-1:0] best_key;

    // Linear scan; a strict compare keeps the earlier slot on a tie.
    always_comb begin
        any      = 1'b0;
        idx      = '0;
        best_key = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (req[i] && (!any || keys[i] < best_key)) begin
                any      = 1'b1;
                idx      = IDX_W'(i);
                best_key = keys[i];
            end
        end
    end

    // R4: the winner is always a requesting slot.
    a_r4_pick_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> req[idx]);

    // R4: no requesting slot holds a strictly smaller key than the winner.
    always_comb begin
        if (rst_n && any) begin
            for (int i = 0; i < NBUF; i++) begin
                a_r4_pick_is_min: assert (!(req[i] && keys[i] < keys[idx]));
            end
        end
    end
endmodule

// File: rtl/txq_ctrl.sv
// Module: txq_ctrl
// Keeps the pending and transmitted flags, the in-flight slot, the free-slot
// index and the post-success pause counter.
// Assumes: the engine sends one completion per take. A completion with
// nothing in flight is ignored.
module txq_ctrl #(
    parameter int NBUF      = 3,
    parameter int PAUSE_CYC = 4,
    localparam int IDX_W    = $clog2(NBUF),
    localparam int PCW      = $clog2(PAUSE_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_single_shot,
    input  logic             cfg_pause_en,
    input  logic [NBUF-1:0]  add_req,
    input  logic             pick_any,
    input  logic [IDX_W-1:0] pick_idx,
    input  logic             eng_take,
    input  logic             eng_done,
    input  logic [1:0]       eng_res,
    output logic [NBUF-1:0]  pend,
    output logic [NBUF-1:0]  sent,
    output logic             offer,
    output logic [IDX_W-1:0] put_idx,
    output logic             full
);
    import txq_pkg::*;

    logic [NBUF-1:0]  pend_q, sent_q;
    logic             busy_q;
    logic [IDX_W-1:0] cur_q;
    logic [PCW-1:0]   pause_q;
    logic             take_ok, fin, fin_ok, fin_drop;

    assign offer    = pick_any && !busy_q && (pause_q == '0);
    assign take_ok  = eng_take && offer;
    assign fin      = eng_done && busy_q;
    assign fin_ok   = fin && (txq_res_e'(eng_res) == RES_OK);
    assign fin_drop = fin && (txq_res_e'(eng_res) != RES_OK) && cfg_single_shot;
    assign pend     = pend_q;
    assign sent     = sent_q;
    assign full     = &pend_q;

    // Lowest free slot, 0 when none is free.
    always_comb begin
        logic found;
        found   = 1'b0;
        put_idx = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (!pend_q[i] && !found) begin
                found   = 1'b1;
                put_idx = IDX_W'(i);
            end
        end
    end

    // Per-slot pending and transmitted flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            sent_q <= '0;
        end else begin
            for (int i = 0; i < NBUF; i++) begin
                if ((fin_ok || fin_drop) && cur_q == IDX_W'(i)) pend_q[i] <= 1'b0;
                if (fin_ok && cur_q == IDX_W'(i))               sent_q[i] <= 1'b1;
                if (add_req[i] && !pend_q[i]) begin
                    pend_q[i] <= 1'b1;
                    sent_q[i] <= 1'b0;
                end
            end
        end
    end

    // In-flight tracking between take and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cur_q  <= '0;
        end else if (take_ok) begin
            busy_q <= 1'b1;
            cur_q  <= pick_idx;
        end else if (fin) begin
            busy_q <= 1'b0;
        end
    end

    // Idle counter that holds back the offer after a success.
    always_ff @(posedge clk) begin
        if (!rst_n)                     pause_q <= '0;
        else if (fin_ok && cfg_pause_en) pause_q <= PCW'(PAUSE_CYC);
        else if (pause_q != '0)          pause_q <= pause_q - 1'b1;
    end

    // R5: a success frees the in-flight slot and flags it as sent.
    a_r5_ok_frees: assert property (@(posedge clk) disable iff (!rst_n)
        fin_ok |=> (!pend_q[$past(cur_q)] && sent_q[$past(cur_q)]));

    // R6: with retries on, a failed slot remains pending.
    a_r6_retry_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && eng_res != 2'd0 && !cfg_single_shot) |=> pend_q[$past(cur_q)]);

    // R7: in single-shot mode a failed slot is freed without the sent flag.
    a_r7_single_try: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && eng_res != 2'd0 && cfg_single_shot)
            |=> (!pend_q[$past(cur_q)] && !sent_q[$past(cur_q)]));

    // R8: the cycle after a paused success offers nothing.
    a_r8_pause_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_ok && cfg_pause_en) |=> !offer);

    // R3: an accepted add makes the slot count as occupied next cycle.
    a_r3_add_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (add_req[0] && !pend_q[0]) |=> (pend_q[0] && !sent_q[0]));
endmodule

// File: rtl/prio_txq.sv
// Module: prio_txq (top)
// A priority-ordered transmit queue: slot storage, a lowest-identifier
// selector and the queue controller, wired to the writer and engine sides.
// Assumes: NBUF >= 2, PAY_WORDS >= 1, PAUSE_CYC >= 1.
module prio_txq #(
    parameter int NBUF      = 3,
    parameter int PAY_WORDS = 2,
    parameter int PAUSE_CYC = 4,
    localparam int IDX_W    = $clog2(NBUF),
    localparam int WSEL_W   = $clog2(PAY_WORDS + 2)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_single_shot,
    input  logic                      cfg_pause_en,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_buf,
    input  logic [WSEL_W-1:0]         wr_word,
    input  logic [31:0]               wr_data,
    input  logic [NBUF-1:0]           add_req,
    output logic [IDX_W-1:0]          put_idx,
    output logic                      queue_full,
    output logic [NBUF-1:0]           tx_sent,
    output logic                      eng_valid,
    output logic [IDX_W-1:0]          eng_buf,
    output logic [31:0]               eng_hdr0,
    output logic [31:0]               eng_hdr1,
    output logic [PAY_WORDS*32-1:0]   eng_payload,
    input  logic                      eng_take,
    input  logic                      eng_done,
    input  logic [1:0]                eng_res
);
    import txq_pkg::*;

    logic [NBUF-1:0]          pend;
    logic [NBUF-1:0][ID_W-1:0] keys;
    logic                     pick_any;
    logic [IDX_W-1:0]         pick_idx;

    txq_store #(.NBUF(NBUF), .PAY_WORDS(PAY_WORDS)) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_buf(wr_buf),
        .wr_word(wr_word), .wr_data(wr_data), .pend(pend), .rd_buf(pick_idx),
        .keys(keys), .rd_hdr0(eng_hdr0), .rd_hdr1(eng_hdr1), .rd_pay(eng_payload)
    );

    txq_pick #(.NBUF(NBUF), .KEY_W(ID_W)) pick_i (
        .clk(clk), .rst_n(rst_n), .req(pend), .keys(keys),
        .any(pick_any), .idx(pick_idx)
    );

    txq_ctrl #(.NBUF(NBUF), .PAUSE_CYC(PAUSE_CYC)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .cfg_single_shot(cfg_single_shot),
        .cfg_pause_en(cfg_pause_en), .add_req(add_req), .pick_any(pick_any),
        .pick_idx(pick_idx), .eng_take(eng_take), .eng_done(eng_done),
        .eng_res(eng_res), .pend(pend), .sent(tx_sent), .offer(eng_valid),
        .put_idx(put_idx), .full(queue_full)
    );

    assign eng_buf = pick_idx;

    // R1: nothing is offered in the first cycle after reset.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> !eng_valid);
endmodule

// File: tb/prio_txq_tb_top.sv
// Bench: directed corner cases, then seeded random traffic, all checked
// against a bench-side model of the queue.
module prio_txq_tb_top;
    localparam int NB = 3;
    localparam int PW = 2;
    localparam int PC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_single_shot = 1'b0, cfg_pause_en = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_buf = '0;
    logic [1:0] wr_word = '0;
    logic [31:0] wr_data = '0;
    logic [NB-1:0] add_req = '0;
    logic [1:0] put_idx;
    logic queue_full;
    logic [NB-1:0] tx_sent;
    logic eng_valid;
    logic [1:0] eng_buf;
    logic [31:0] eng_hdr0, eng_hdr1;
    logic [PW*32-1:0] eng_payload;
    logic eng_take = 1'b0, eng_done = 1'b0;
    logic [1:0] eng_res = '0;

    always #2.5 clk = ~clk;

    prio_txq #(.NBUF(NB), .PAY_WORDS(PW), .PAUSE_CYC(PC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_single_shot(cfg_single_shot),
        .cfg_pause_en(cfg_pause_en), .wr_en(wr_en), .wr_buf(wr_buf),
        .wr_word(wr_word), .wr_data(wr_data), .add_req(add_req),
        .put_idx(put_idx), .queue_full(queue_full), .tx_sent(tx_sent),
        .eng_valid(eng_valid), .eng_buf(eng_buf), .eng_hdr0(eng_hdr0),
        .eng_hdr1(eng_hdr1), .eng_payload(eng_payload), .eng_take(eng_take),
        .eng_done(eng_done), .eng_res(eng_res)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    // Bench model state.
    logic [31:0] m_h0 [NB], m_h1 [NB];
    logic [31:0] m_pay [NB][PW];
    bit m_pend [NB], m_sent [NB];
    bit m_busy;
    int m_cur, m_pause;

    task automatic chk(input bit ok, input string tag, input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int m_sel();
        int b = -1;
        for (int i = 0; i < NB; i++)
            if (m_pend[i] && (b < 0 || m_h0[i][28:0] < m_h0[b][28:0])) b = i;
        return b;
    endfunction

    function automatic bit m_valid();
        return (m_sel() >= 0) && !m_busy && (m_pause == 0);
    endfunction

    function automatic int m_put();
        for (int i = 0; i < NB; i++) if (!m_pend[i]) return i;
        return 0;
    endfunction

    task automatic compare();
        int s = m_sel();
        bit v = m_valid();
        bit f = m_pend[0] && m_pend[1] && m_pend[2];
        logic [NB-1:0] st;
        for (int i = 0; i < NB; i++) st[i] = m_sent[i];
        chk(put_idx == 2'(m_put()), "R2/R3 put_idx", put_idx, m_put());
        chk(queue_full == f, "R2 queue_full", queue_full, f);
        chk(tx_sent == st, "R5/R7 tx_sent", tx_sent, st);
        chk(eng_valid == v, "R5/R8 eng_valid", eng_valid, v);
        if (v) begin
            chk(eng_buf == 2'(s), "R4/R6 eng_buf", eng_buf, s);
            chk(eng_hdr0 == m_h0[s] && eng_hdr1 == m_h1[s], "R9 headers",
                {eng_hdr0, eng_hdr1}, {m_h0[s], m_h1[s]});
            chk(eng_payload == {m_pay[s][1], m_pay[s][0]}, "R9 payload",
                eng_payload, {m_pay[s][1], m_pay[s][0]});
        end
    endtask

    // One clock: drive at the falling edge, update the model at the rising edge, compare after it.
    task automatic step(input bit we, input int b, input int w, input logic [31:0] d,
                        input logic [NB-1:0] add, input bit tk, input bit dn, input logic [1:0] rs);
        bit v = m_valid();
        int s = m_sel();
        bit old_pend [NB];
        wr_en = we; wr_buf = 2'(b); wr_word = 2'(w); wr_data = d;
        add_req = add; eng_take = tk; eng_done = dn; eng_res = rs;
        @(posedge clk);
        for (int i = 0; i < NB; i++) old_pend[i] = m_pend[i];
        if (we && !old_pend[b]) begin
            if (w == 0) m_h0[b] = d;
            else if (w == 1) m_h1[b] = d;
            else m_pay[b][w-2] = d;
        end
        if (dn && m_busy) begin
            if (rs == 2'd0) begin
                m_pend[m_cur] = 1'b0; m_sent[m_cur] = 1'b1;
            end else if (cfg_single_shot) begin
                m_pend[m_cur] = 1'b0;
            end
            m_busy = 1'b0;
            if (rs == 2'd0 && cfg_pause_en) m_pause = PC;
            else if (m_pause > 0) m_pause--;
        end else if (m_pause > 0) begin
            m_pause--;
        end
        if (tk && v) begin m_busy = 1'b1; m_cur = s; end
        for (int i = 0; i < NB; i++)
            if (add[i] && !old_pend[i]) begin m_pend[i] = 1'b1; m_sent[i] = 1'b0; end
        #1;
        compare();
        @(negedge clk);
        wr_en = 1'b0; add_req = '0; eng_take = 1'b0; eng_done = 1'b0;
    endtask

    task automatic idle(); step(0, 0, 0, 0, '0, 0, 0, 0); endtask

    initial begin
        for (int i = 0; i < NB; i++) begin
            m_h0[i] = '0; m_h1[i] = '0; m_pend[i] = 0; m_sent[i] = 0;
            for (int k = 0; k < PW; k++) m_pay[i][k] = '0;
        end
        m_busy = 0; m_cur = 0; m_pause = 0;
        void'($urandom(32'd20240917));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(put_idx == 0, "R1 put_idx", put_idx, 0);
        chk(queue_full == 0, "R1 queue_full", queue_full, 0);
        chk(tx_sent == 0, "R1 tx_sent", tx_sent, 0);
        chk(eng_valid == 0, "R1 eng_valid", eng_valid, 0);
        @(negedge clk);

        // Directed: equal ids in slots 0 and 1, lower id in slot 2 (R4 tie rule).
        step(1, 0, 0, 32'h4000_0009, '0, 0, 0, 0);
        step(1, 0, 2, 32'hAAAA_0000, '0, 0, 0, 0);
        step(1, 1, 0, 32'h4000_0009, '0, 0, 0, 0);
        step(1, 2, 0, 32'h4000_0004, '0, 0, 0, 0);
        step(1, 2, 3, 32'h1234_5678, 3'b011, 0, 0, 0);
        chk(eng_buf == 0, "R4 tie to lower slot", eng_buf, 0);
        chk(put_idx == 2, "R2 lowest free", put_idx, 2);
        step(0, 0, 0, 0, 3'b100, 0, 0, 0);
        chk(queue_full == 1 && put_idx == 0, "R2 full", {queue_full, put_idx}, 3'b100);
        chk(eng_buf == 2, "R4 lowest id", eng_buf, 2);
        // R9: overwrite of a pending slot is dropped; R3: repeated add has no effect.
        step(1, 2, 0, 32'h4000_0001, 3'b100, 0, 0, 0);
        chk(eng_hdr0 == 32'h4000_0004, "R9 pending write ignored", eng_hdr0, 32'h4000_0004);
        // R6: arbitration loss with retries keeps slot 2 on offer.
        step(0, 0, 0, 0, '0, 1, 0, 0);
        chk(eng_valid == 0, "R5 no offer in flight", eng_valid, 0);
        step(0, 0, 0, 0, '0, 0, 1, 2'd1);
        chk(eng_valid == 1 && eng_buf == 2, "R6 retried", eng_buf, 2);
        // R8: success with pause.
        cfg_pause_en = 1'b1;
        step(0, 0, 0, 0, '0, 1, 0, 0);
        step(0, 0, 0, 0, '0, 0, 1, 2'd0);
        chk(tx_sent == 3'b100, "R5 sent flag", tx_sent, 3'b100);
        for (int c = 0; c < PC - 1; c++) idle();
        chk(eng_valid == 0, "R8 still paused", eng_valid, 0);
        idle();
        chk(eng_valid == 1 && eng_buf == 0, "R8 pause over", eng_buf, 0);
        // R7: single-shot error frees slot 0 without the sent flag.
        cfg_single_shot = 1'b1;
        step(0, 0, 0, 0, '0, 1, 0, 0);
        step(0, 0, 0, 0, '0, 0, 1, 2'd2);
        chk(put_idx == 0 && tx_sent[0] == 0, "R7 freed unsent", {tx_sent, put_idx}, 5'b10000);

        // Random phases.
        for (int ph = 0; ph < 6; ph++) begin
            cfg_single_shot = ph[0];
            cfg_pause_en = ph[1];
            for (int n = 0; n < 500; n++) begin
                int b = int'($urandom % NB);
                int w = int'($urandom % (PW + 2));
                logic [31:0] d = $urandom;
                if (w == 0) d[28:0] = 29'($urandom % 6);
                step(($urandom % 2) == 0, b, w, d,
                     (($urandom % 4) == 0) ? 3'($urandom) : 3'b000,
                     ($urandom % 2) == 0, ($urandom % 3) == 0, 2'($urandom));
            end
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule